// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the master side of a two-wire PHY management link using Clause 22 frames. A single write of a 32-bit frame word starts a whole transaction. The word carries the start pattern, the opcode, the PHY address, the register address, the turnaround pattern and 16 data bits. The block derives the management clock (MDC) from the system clock. It first sends a preamble of 32 ones, then the frame, most significant bit first. MDIO changes a programmable number of system clocks after each falling edge of MDC, so the PHY always samples a settled level on the rising edge.

For a read, the block releases MDIO from the turnaround bits to the end of the frame. It samples the 16 bits that the PHY returns on the MDC rising edges and writes them over the data field of the frame word. At the end of every frame a sticky completion flag is set. Software clears this flag by writing 1 to it before it starts a frame, and then polls until the flag is set again. Two configuration fields set the MDC divider and the MDIO hold delay.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdc, mdio_o, mdio_oe and done_evt are 0, and frame_q is all zeros.
- R2: A frame_wr pulse while idle, whose opcode field (frame bits 29:28) is 01 (write) or 10 (read), loads frame_q with frame_wdata and raises busy on the next clock edge.
- R3: A frame_wr pulse whose opcode field is 00 or 11 is ignored. busy stays 0, frame_q keeps its value and MDC stays low.
- R4: MDIO (both mdio_o and mdio_oe) changes only while MDC is low. It changes exactly min(H, S'-1)+1 system clocks after an MDC falling edge, where H is hold_cfg, S is speed_cfg and S' is S, or 1 when S is 0.
- R5: MDC is low whenever the block is idle. Its first rising edge comes S'+1 system clocks after busy rises, and its period is 2*(S'+1) system clocks.
- R6: On each of the 64 MDC rising edges of a write frame, mdio_oe is 1. mdio_o is 1 for the first 32 edges, then carries frame bits 31 down to 0.
- R7: In a read frame (opcode 10), mdio_oe is 0 from the turnaround bit (frame bit 17, the 47th line bit) through the last bit. The 16 bits sampled on the last 16 rising edges, first bit as MSB, replace frame_q[15:0]. frame_q[31:16] keeps its value.
- R8: On the falling edge that ends the 64th bit, busy drops, done_evt is set and mdio_oe drops, all on the same clock edge.
- R9: A done_clr pulse clears done_evt on the next edge. If completion and done_clr fall on the same edge, done_evt is set.
- R10: A frame_wr pulse while busy is ignored. The frame in flight and frame_q are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_wr | input | 1 | Write strobe for the frame word; starts a transaction |
| frame_wdata | input | 32 | Frame word to load |
| done_clr | input | 1 | Write-1-to-clear strobe for the completion flag |
| speed_cfg | input | 8 | MDC divider; half period is speed_cfg+1 system clocks |
| hold_cfg | input | 8 | MDIO hold delay after the MDC falling edge |
| frame_q | output | 32 | Frame word; its low 16 bits hold read data after a read |
| done_evt | output | 1 | Sticky completion flag |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output level |
| mdio_oe | output | 1 | MDIO output enable (0 releases the line) |
| mdio_i | input | 1 | MDIO input level |

## Verification
The bench targets the hold clamp. With a hold value larger than the half period, a design that does not clamp would move MDIO while MDC is high or across a rising edge, and the hold-delay check would fail. A speed of zero checks the minimum divider: a design that divides by zero would either stall or run MDC at the system rate. A read returns a pattern with both end bits set, which exposes an off-by-one in the sampling window or a reversed bit order. The bench also holds done_clr high while a frame ends, which exposes a completion flag where clear wins over set. A write to frame_wr in the middle of a frame exposes a design that restarts or reloads its frame word.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_W    = 32;
  localparam int PRE_BITS   = 32;
  localparam int TOTAL_BITS = PRE_BITS + FRAME_W;
  localparam int DATA_W     = 16;
  localparam int CFG_W      = 8;

  // opcode position inside the frame word
  localparam int OP_HI = 29;
  localparam int OP_LO = 28;
  // positions counted from the MSB of the frame (0 = first bit on the line)
  localparam int TA_POS = 14;
  localparam int RD_POS = 16;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef logic [CFG_W-1:0] cfg_t;

  function automatic logic op_supported(input logic [1:0] op);
    return (op == OP_WR) || (op == OP_RD);
  endfunction

  // divider value actually used: zero behaves as one
  function automatic cfg_t eff_speed(input cfg_t s);
    return (s == '0) ? cfg_t'(1) : s;
  endfunction

  // hold delay clamped so MDIO settles before the next rising edge
  function automatic cfg_t eff_hold(input cfg_t h, input cfg_t s);
    cfg_t se;
    se = eff_speed(s);
    return (h >= se) ? (se - 1'b1) : h;
  endfunction

  // level on the line for a given bit position of the 64-bit sequence
  function automatic logic line_bit(input logic [FRAME_W-1:0] f, input int unsigned pos);
    if (pos < PRE_BITS) return 1'b1;
    return f[FRAME_W-1-int'(pos-PRE_BITS)];
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cfg_t speed,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);

  cfg_t cnt;
  logic edge_now;

  assign edge_now = run && (cnt >= eff_speed(speed));
  assign rise_evt = edge_now && !mdc;
  assign fall_evt = edge_now && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  cfg_t               speed,
  input  cfg_t               hold,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               mdio_i,
  output logic               run,
  output logic               is_rd,
  output logic               fin,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mdio_o,
  output logic               mdio_oe
);

  localparam int IDX_W = $clog2(TOTAL_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + TA_POS);
  localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(PRE_BITS + RD_POS);

  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] txf;
  logic               pend;
  cfg_t               hcnt;
  logic               last_bit;
  logic               launch;

  assign last_bit = (idx == LAST_IDX);
  assign fin      = run && fall_evt && last_bit;
  assign launch   = pend && (hcnt >= eff_hold(hold, speed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      is_rd   <= 1'b0;
      idx     <= '0;
      txf     <= '0;
      pend    <= 1'b0;
      hcnt    <= '0;
      rd_data <= '0;
    end else if (!run) begin
      if (start) begin
        run     <= 1'b1;
        idx     <= '0;
        txf     <= frame_in;
        is_rd   <= (frame_in[OP_HI:OP_LO] == OP_RD);
        pend    <= 1'b0;
        hcnt    <= '0;
        rd_data <= '0;
      end
    end else begin
      if (fall_evt) begin
        run  <= !last_bit;
        pend <= !last_bit;
        hcnt <= '0;
      end else if (launch) begin
        idx  <= idx + 1'b1;
        pend <= 1'b0;
      end else if (pend) begin
        hcnt <= hcnt + 1'b1;
      end
      if (rise_evt && is_rd && (idx >= RD_IDX)) begin
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
    end
  end

  assign mdio_o  = run && line_bit(txf, 32'(idx));
  assign mdio_oe = run && !(is_rd && (idx >= TA_IDX));

endmodule

// File: rtl/mdio_frame_reg.sv
module mdio_frame_reg
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [FRAME_W-1:0] wdata,
  input  logic               clr,
  input  logic               busy,
  input  logic               fin,
  input  logic               fin_rd,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               start,
  output logic [FRAME_W-1:0] frame_q,
  output logic               done_evt
);

  assign start = wr && !busy && op_supported(wdata[OP_HI:OP_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (start) begin
      frame_q <= wdata;
    end else if (fin && fin_rd) begin
      frame_q[DATA_W-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_evt <= 1'b0;
    end else if (fin) begin
      done_evt <= 1'b1;
    end else if (clr) begin
      done_evt <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_wr,
  input  logic [FRAME_W-1:0] frame_wdata,
  input  logic               done_clr,
  input  logic [CFG_W-1:0]   speed_cfg,
  input  logic [CFG_W-1:0]   hold_cfg,
  output logic [FRAME_W-1:0] frame_q,
  output logic               done_evt,
  output logic               busy,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);

  logic              seq_start;
  logic              seq_fin;
  logic              seq_rd;
  logic              mdc_rise;
  logic              mdc_fall;
  logic [DATA_W-1:0] seq_rdata;

  mdio_frame_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (frame_wr),
    .wdata    (frame_wdata),
    .clr      (done_clr),
    .busy     (busy),
    .fin      (seq_fin),
    .fin_rd   (seq_rd),
    .rd_data  (seq_rdata),
    .start    (seq_start),
    .frame_q  (frame_q),
    .done_evt (done_evt)
  );

  mdio_clk_gen u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .speed    (speed_cfg),
    .mdc      (mdc),
    .rise_evt (mdc_rise),
    .fall_evt (mdc_fall)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .frame_in (frame_wdata),
    .speed    (speed_cfg),
    .hold     (hold_cfg),
    .rise_evt (mdc_rise),
    .fall_evt (mdc_fall),
    .mdio_i   (mdio_i),
    .run      (busy),
    .is_rd    (seq_rd),
    .fin      (seq_fin),
    .rd_data  (seq_rdata),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               frame_wr,
  input logic [FRAME_W-1:0] frame_wdata,
  input logic               done_clr,
  input logic [FRAME_W-1:0] frame_q,
  input logic               done_evt,
  input logic               busy,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic               seq_fin
);

  logic op_ok;
  assign op_ok = op_supported(frame_wdata[OP_HI:OP_LO]);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !busy && op_ok) |=> (busy && frame_q == $past(frame_wdata)));

  p_bad_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !busy && !op_ok) |=> (!busy && $stable(frame_q)));

  p_steady_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_evt && !mdio_oe));

  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !seq_fin) |=> !done_evt);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fin |=> done_evt);

  p_busy_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && busy && !seq_fin) |=> $stable(frame_q));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_wr    (frame_wr),
  .frame_wdata (frame_wdata),
  .done_clr    (done_clr),
  .frame_q     (frame_q),
  .done_evt    (done_evt),
  .busy        (busy),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .seq_fin     (seq_fin)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  import mdio_pkg::*;

  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic done_clr = 1'b0;
  logic [7:0] speed_cfg = 8'd3;
  logic [7:0] hold_cfg = 8'd1;
  logic [31:0] frame_q;
  logic done_evt, busy, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .done_clr(done_clr), .speed_cfg(speed_cfg), .hold_cfg(hold_cfg),
    .frame_q(frame_q), .done_evt(done_evt), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0;
  int bad = 0;
  logic [1:0] exp_q[$];
  int exp_half = 4;
  int exp_hold = 1;
  logic [15:0] phy_rdval = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: scoreboard of line bits, MDC timing, hold timing, PHY responder
  int cyc = 0;
  int start_cyc = 0, last_fall = 0, last_rise = 0, rises = 0;
  bit seen_fall = 0, seen_rise = 0;
  logic prev_mdc = 0, prev_o = 0, prev_oe = 0, prev_busy = 0;

  always @(negedge clk) begin
    logic [1:0] item;
    cyc++;
    if (cyc > WD_LIMIT) begin
      check(0, "R8", "watchdog expired", cyc, WD_LIMIT);
      finish_run();
    end
    if (rst_n) begin
      if (busy && !prev_busy) begin
        start_cyc = cyc; seen_fall = 0; seen_rise = 0; rises = 0; mdio_i = 1'b1;
      end
      if (busy && mdc && !prev_mdc) begin
        if (!seen_rise) check(cyc - start_cyc == exp_half, "R5", "first rise delay", cyc - start_cyc, exp_half);
        else check(cyc - last_rise == 2 * exp_half, "R5", "mdc period", cyc - last_rise, 2 * exp_half);
        seen_rise = 1; last_rise = cyc;
        if (exp_q.size() == 0) begin
          check(0, "R6", "extra bit on line", 1, 0);
        end else begin
          item = exp_q.pop_front();
          check(mdio_oe == item[1], item[1] ? "R6" : "R7", "mdio_oe at rise", mdio_oe, item[1]);
          if (item[1]) check(mdio_o == item[0], "R6", "mdio_o at rise", mdio_o, item[0]);
        end
        rises++;
        mdio_i = (rises >= 48 && rises <= 63) ? phy_rdval[63 - rises] : 1'b1;
      end
      if (busy && !mdc && prev_mdc) begin
        seen_fall = 1; last_fall = cyc;
      end
      if (busy && prev_busy && (mdio_o != prev_o || mdio_oe != prev_oe)) begin
        check(!mdc, "R4", "mdio change while mdc high", mdc, 0);
        check(seen_fall && (cyc - last_fall == exp_hold + 1), "R4", "hold delay",
              cyc - last_fall, exp_hold + 1);
      end
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_busy = busy;
  end

  task automatic launch(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] d, input int s, input int h,
                        input logic [15:0] rdv, output logic [31:0] f);
    int se;
    f = {2'b01, op, pa, ra, 2'b10, d};
    se = (s == 0) ? 1 : s;
    exp_half = se + 1;
    exp_hold = (h >= se) ? se - 1 : h;
    speed_cfg = 8'(s);
    hold_cfg = 8'(h);
    phy_rdval = rdv;
    for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
    for (int i = 0; i < 32; i++) begin
      if (op == OP_RD && i >= TA_POS) exp_q.push_back(2'b00);
      else exp_q.push_back({1'b1, f[31 - i]});
    end
    @(negedge clk); frame_wr = 1'b1; frame_wdata = f;
    @(negedge clk); frame_wr = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(frame_q == f, "R2", "frame_q loaded", frame_q, f);
  endtask

  task automatic finish(input logic [1:0] op, input logic [31:0] f, input logic [15:0] rdv);
    int n;
    n = 0;
    while (busy && n < 40000) begin
      @(negedge clk); n++;
    end
    check(!busy, "R8", "frame ended", busy, 0);
    check(done_evt == 1'b1, "R8", "done set at end", done_evt, 1);
    check(mdio_oe == 1'b0, "R8", "line released", mdio_oe, 0);
    check(mdc == 1'b0, "R5", "mdc idle low", mdc, 0);
    check(exp_q.size() == 0, "R6", "bits remaining", exp_q.size(), 0);
    if (op == OP_RD) check(frame_q == {f[31:16], rdv}, "R7", "read data", frame_q, {f[31:16], rdv});
    else check(frame_q == f, "R6", "frame_q after write", frame_q, f);
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    check(done_evt == 1'b0, "R9", "done cleared", done_evt, 0);
  endtask

  initial begin
    logic [31:0] f;
    logic [31:0] keep;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1", "busy", busy, 0);
    check(mdc == 0, "R1", "mdc", mdc, 0);
    check(mdio_o == 0 && mdio_oe == 0, "R1", "mdio", {mdio_oe, mdio_o}, 0);
    check(done_evt == 0, "R1", "done", done_evt, 0);
    check(frame_q == 0, "R1", "frame_q", frame_q, 0);

    // plain write
    launch(OP_WR, 5'h03, 5'h1A, 16'hA5C3, 3, 1, 16'h0, f);
    finish(OP_WR, f, 16'h0);
    clear_done();

    // read with both end bits set in the returned data
    launch(OP_RD, 5'h11, 5'h02, 16'h1234, 3, 1, 16'h8181, f);
    finish(OP_RD, f, 16'h8181);
    clear_done();

    // unsupported opcodes are ignored
    keep = frame_q;
    @(negedge clk); frame_wr = 1'b1; frame_wdata = {2'b01, 2'b11, 28'h5A5A5A5};
    @(negedge clk); frame_wr = 1'b0;
    check(busy == 0, "R3", "op 11 no start", busy, 0);
    check(frame_q == keep, "R3", "op 11 frame_q", frame_q, keep);
    @(negedge clk); frame_wr = 1'b1; frame_wdata = {2'b01, 2'b00, 28'h0F0F0F0};
    @(negedge clk); frame_wr = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 0 && mdc == 0, "R3", "op 00 no start", {busy, mdc}, 0);
    check(frame_q == keep, "R3", "op 00 frame_q", frame_q, keep);
    check(done_evt == 0, "R3", "no completion", done_evt, 0);

    // write while busy is ignored
    launch(OP_WR, 5'h1F, 5'h00, 16'h0FF0, 3, 0, 16'h0, f);
    repeat (100) @(negedge clk);
    frame_wr = 1'b1; frame_wdata = {2'b01, OP_RD, 5'h01, 5'h01, 2'b10, 16'hDEAD};
    @(negedge clk); frame_wr = 1'b0;
    check(frame_q == f, "R10", "frame_q during busy write", frame_q, f);
    finish(OP_WR, f, 16'h0);
    clear_done();

    // hold larger than half period is clamped
    launch(OP_WR, 5'h0A, 5'h15, 16'h5A3C, 3, 7, 16'h0, f);
    finish(OP_WR, f, 16'h0);
    clear_done();

    // speed zero behaves as one
    launch(OP_RD, 5'h04, 5'h1E, 16'h0000, 0, 5, 16'h7E01, f);
    finish(OP_RD, f, 16'h7E01);
    clear_done();

    // slow divider; clear held across completion (set wins)
    launch(OP_WR, 5'h01, 5'h09, 16'hC001, 120, 10, 16'h0, f);
    done_clr = 1'b1;
    finish(OP_WR, f, 16'h0);
    @(negedge clk);
    check(done_evt == 1'b0, "R9", "clear after set-wins", done_evt, 0);
    done_clr = 1'b0;

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule